// File: doc/BRIEF.md
# Block-Transfer Sequencer

This block carries out one multi-register load or store instruction of a 32-bit CPU, moving one word per memory beat. After a start pulse in the idle state it decodes the instruction word. It reads the base register and then visits the set bits of a 16-bit register mask, one per beat. For each visited register it issues a word address to a simple request/ready memory port. A load writes the returned word into the register file. A store drives the register's value onto the port. The register file has current-mode entries and a separate user-mode copy of registers 8 to 14. Register 15 is the program counter and has its own input and write port.

The controller has three states. ST_IDLE waits for a valid start. ST_XFER runs one beat per accepted memory cycle. ST_FINISH lasts one cycle: it raises `done` and, when requested, writes the final address back to the base register. The transitions are:
- ST_IDLE to ST_XFER on a valid start with a non-empty mask.
- ST_IDLE to ST_FINISH on a valid start with an empty mask.
- ST_XFER to itself while beats remain or the port stalls.
- ST_XFER to ST_FINISH when the last beat is accepted.
- ST_FINISH to ST_IDLE unconditionally.

The four addressing modes combine increment or decrement with stepping the address before or after each access. A bank flag redirects registers 8 to 14 to the user copy. The redirect is cancelled when register 15 is in the mask. In that case a load of register 15 also asks the surrounding core to restore its saved status.

Top module: `blkxfer_seq`

## Requirements
- R1: A start is taken only in ST_IDLE and only when instruction bits 27:25 equal 3'b100. The other fields are read as follows: bit 24 steps the address before each access (pre), bit 23 selects increment, bit 22 is the bank flag, bit 21 requests writeback, bit 20 selects load (1) or store (0), bits 19:16 give the base register, and bits 15:0 give the mask. Any other start leaves `busy`, `done` and `mem_req` low.
- R2: In increment mode the set mask bits are visited from 0 up to 15 and the address grows by 4 per beat. In decrement mode they are visited from 15 down to 0 and the address shrinks by 4 per beat. Clear bits take no beat and do not move the address.
- R3: The working address starts at the base register value. In pre mode each beat uses the working address already stepped by 4. In post mode each beat uses the working address and then steps it.
- R4: With writeback set and a non-empty mask, the final working address is written to the base register through the current-mode register write port in the `done` cycle. This write overrides a value loaded into that register during the transfer.
- R5: With the bank flag set and mask bit 15 clear, registers 8 to 14 are read or written with the user flag high and port index equal to the register number minus 8. Registers 0 to 7 always use the current-mode entries with the user flag low.
- R6: With the bank flag set and mask bit 15 set, registers 8 to 14 use the current-mode entries. A load of register 15 drives the loaded word on the PC write port. When the bank flag is set, that same cycle also pulses `status_restore`; when the bank flag is clear, it does not.
- R7: A store of register 15 writes `pc_in` + 4 in post mode and `pc_in` in pre mode.
- R8: A memory request holds its address and direction unchanged until `mem_ready` is high. Each cycle with both `mem_req` and `mem_ready` high completes exactly one beat.
- R9: `busy` is high from the cycle after the start until the end of the `done` cycle. `done` pulses for one cycle, one cycle after the last beat is accepted.
- R10: An all-zero mask raises `done` one cycle after the start, with no memory beat and no base writeback, even when writeback is requested.
- R11: A start while the block is busy is ignored. The running transfer completes as if no second start had occurred.
- R12: While reset is asserted, `busy`, `done`, `mem_req`, `rf_we`, `pc_we` and `status_restore` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled in ST_IDLE only |
| instr | input | 32 | Block-transfer instruction word |
| pc_in | input | 32 | Current program counter value |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat direction: 1 write, 0 read |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Beat accepted this cycle |
| rf_rd_idx | output | 4 | Register read index (minus 8 for the user copy) |
| rf_rd_usr | output | 1 | Read selects the user-mode copy |
| rf_rd_data | input | 32 | Combinational register read data |
| rf_we | output | 1 | Register write strobe |
| rf_wr_idx | output | 4 | Register write index (minus 8 for the user copy) |
| rf_wr_usr | output | 1 | Write selects the user-mode copy |
| rf_wr_data | output | 32 | Register write data |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | New PC value |
| status_restore | output | 1 | Copy saved status into current status |

## Verification
The embedded properties assume three things about the environment. `rf_rd_data` is a combinational function of the read index and the user flag. `mem_rdata` is valid whenever `mem_ready` is high. `instr` and `pc_in` are held steady while a beat is pending. The bench drives `pc_in` and the instruction before the start pulse and leaves `pc_in` untouched during the run. It answers reads combinationally from its own memory model. It raises `mem_ready` at random, so that stall cycles occur in every mode. A second start is injected mid-transfer only while `busy` is high.

// File: rtl/blkxfer_pkg.sv
`timescale 1ns/1ps
package blkxfer_pkg;
    localparam int XLEN        = 32;
    localparam int NREG        = 16;
    localparam int REG_W       = $clog2(NREG);
    localparam int F_CLASS_LSB = 25;
    localparam int F_PRE       = 24;
    localparam int F_INC       = 23;
    localparam int F_BANK      = 22;
    localparam int F_WB        = 21;
    localparam int F_LOAD      = 20;
    localparam int F_RN_LSB    = 16;
    localparam logic [2:0] CLASS_CODE = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic             valid;
        logic             pre;
        logic             inc;
        logic             bank;
        logic             wb;
        logic             load;
        logic [REG_W-1:0] rn;
        logic [NREG-1:0]  mask;
    } xfer_cmd_t;
endpackage

// File: rtl/blkxfer_decode.sv
`timescale 1ns/1ps
module blkxfer_decode
    import blkxfer_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output xfer_cmd_t       cmd
);
    localparam int TOP_LSB = F_CLASS_LSB + 3;

    logic unused_cond;
    assign unused_cond = ^instr[XLEN-1:TOP_LSB];

    always_comb begin
        cmd.valid = (instr[F_CLASS_LSB +: 3] == CLASS_CODE);
        cmd.pre   = instr[F_PRE];
        cmd.inc   = instr[F_INC];
        cmd.bank  = instr[F_BANK];
        cmd.wb    = instr[F_WB];
        cmd.load  = instr[F_LOAD];
        cmd.rn    = instr[F_RN_LSB +: REG_W];
        cmd.mask  = instr[NREG-1:0];
    end
endmodule

// File: rtl/blkxfer_pick.sv
`timescale 1ns/1ps
module blkxfer_pick #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] pend,
    input  logic         inc,
    output logic         any,
    output logic [W-1:0] idx,
    output logic [N-1:0] rest
);
    logic [W-1:0] lo_idx;
    logic [W-1:0] hi_idx;

    // Lowest set bit serves ascending order, highest serves descending.
    always_comb begin
        lo_idx = '0;
        hi_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) lo_idx = W'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (pend[i]) hi_idx = W'(i);
        end
        idx  = inc ? lo_idx : hi_idx;
        any  = |pend;
        rest = pend & ~(N'(1) << idx);
    end
endmodule

// File: rtl/blkxfer_route.sv
`timescale 1ns/1ps
module blkxfer_route #(
    parameter int W  = 4,
    parameter int LO = 8,
    parameter int HI = 14
) (
    input  logic [W-1:0] reg_idx,
    input  logic         ovr,
    output logic         usr,
    output logic [W-1:0] port_idx
);
    always_comb begin
        usr      = ovr && (reg_idx >= W'(LO)) && (reg_idx <= W'(HI));
        port_idx = usr ? (reg_idx - W'(LO)) : reg_idx;
    end
endmodule

// File: rtl/blkxfer_seq.sv
`timescale 1ns/1ps
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int BANK_LO = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [XLEN-1:0]  instr,
    input  logic [XLEN-1:0]  pc_in,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic [REG_W-1:0] rf_rd_idx,
    output logic             rf_rd_usr,
    input  logic [XLEN-1:0]  rf_rd_data,
    output logic             rf_we,
    output logic [REG_W-1:0] rf_wr_idx,
    output logic             rf_wr_usr,
    output logic [XLEN-1:0]  rf_wr_data,
    output logic             pc_we,
    output logic [XLEN-1:0]  pc_wdata,
    output logic             status_restore
);
    localparam int               BANK_HI = NREG - 2;
    localparam logic [REG_W-1:0] PC_IDX  = REG_W'(NREG - 1);
    localparam logic [XLEN-1:0]  STEP    = XLEN'(4);

    seq_state_e state, state_nx;

    xfer_cmd_t        cmd;
    logic             go;
    logic             pre_q, inc_q, bank_q, load_q, wb_q, ovr_q;
    logic [REG_W-1:0] rn_q;
    logic [NREG-1:0]  pend_q;
    logic [XLEN-1:0]  addr_q;

    logic             pick_any;
    logic [REG_W-1:0] cur_idx;
    logic [NREG-1:0]  pend_rest;
    logic             cur_usr;
    logic [REG_W-1:0] cur_port;
    logic [XLEN-1:0]  addr_step;
    logic             cur_is_pc;
    logic             beat_ok;

    blkxfer_decode u_decode (
        .instr (instr),
        .cmd   (cmd)
    );

    blkxfer_pick #(.N(NREG), .W(REG_W)) u_pick (
        .pend (pend_q),
        .inc  (inc_q),
        .any  (pick_any),
        .idx  (cur_idx),
        .rest (pend_rest)
    );

    blkxfer_route #(.W(REG_W), .LO(BANK_LO), .HI(BANK_HI)) u_route (
        .reg_idx  (cur_idx),
        .ovr      (ovr_q),
        .usr      (cur_usr),
        .port_idx (cur_port)
    );

    assign go        = start && cmd.valid;
    assign addr_step = inc_q ? (addr_q + STEP) : (addr_q - STEP);
    assign cur_is_pc = (cur_idx == PC_IDX);
    assign beat_ok   = (state == ST_XFER) && mem_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go) state_nx = (|cmd.mask) ? ST_XFER : ST_FINISH;
            end
            ST_XFER: begin
                if (mem_ready && !(|pend_rest)) state_nx = ST_FINISH;
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Command capture and address walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= 1'b0;
            inc_q  <= 1'b0;
            bank_q <= 1'b0;
            load_q <= 1'b0;
            wb_q   <= 1'b0;
            ovr_q  <= 1'b0;
            rn_q   <= '0;
            pend_q <= '0;
            addr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        pre_q  <= cmd.pre;
                        inc_q  <= cmd.inc;
                        bank_q <= cmd.bank;
                        load_q <= cmd.load;
                        wb_q   <= cmd.wb && (|cmd.mask);
                        ovr_q  <= cmd.bank && !cmd.mask[NREG-1];
                        rn_q   <= cmd.rn;
                        pend_q <= cmd.mask;
                        addr_q <= rf_rd_data;
                    end
                end
                ST_XFER: begin
                    if (mem_ready) begin
                        addr_q <= addr_step;
                        pend_q <= pend_rest;
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy           = (state != ST_IDLE);
        done           = 1'b0;
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = pre_q ? addr_step : addr_q;
        mem_wdata      = rf_rd_data;
        rf_rd_idx      = cmd.rn;
        rf_rd_usr      = 1'b0;
        rf_we          = 1'b0;
        rf_wr_idx      = cur_port;
        rf_wr_usr      = 1'b0;
        rf_wr_data     = mem_rdata;
        pc_we          = 1'b0;
        pc_wdata       = mem_rdata;
        status_restore = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_XFER: begin
                mem_req   = 1'b1;
                mem_we    = !load_q;
                rf_rd_idx = cur_port;
                rf_rd_usr = cur_usr;
                rf_wr_usr = cur_usr;
                if (cur_is_pc) mem_wdata = pre_q ? pc_in : (pc_in + STEP);
                rf_we          = beat_ok && load_q && !cur_is_pc;
                pc_we          = beat_ok && load_q && cur_is_pc;
                status_restore = beat_ok && load_q && cur_is_pc && bank_q;
            end
            ST_FINISH: begin
                done       = 1'b1;
                rf_we      = wb_q;
                rf_wr_idx  = rn_q;
                rf_wr_data = addr_q;
            end
            default: ;
        endcase
    end

    // Checks kept next to the logic they guard
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && (|pend_rest)) |=>
        (mem_addr == (inc_q ? ($past(mem_addr) + STEP) : ($past(mem_addr) - STEP))));

    assert_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> pick_any);

    assert_usr_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd_usr || rf_wr_usr) |-> (mem_req && (rf_rd_idx <= REG_W'(BANK_HI - BANK_LO))));

    assert_onewrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rf_we, pc_we}) <= 1);

    assert_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_restore |-> (mem_req && mem_ready && !mem_we));

    assert_cmd_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(rn_q) && $stable(load_q) && $stable(inc_q) && $stable(pre_q)));
endmodule

// File: tb/blkxfer_seq_tb.sv
`timescale 1ns/1ps
module blkxfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] instr;
    logic [31:0] pc_in;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready;
    logic [3:0]  rf_rd_idx, rf_wr_idx;
    logic        rf_rd_usr, rf_wr_usr, rf_we, pc_we, status_restore;
    logic [31:0] rf_rd_data, rf_wr_data, pc_wdata;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    // environment models (written only at the clock edge)
    logic [31:0] rf_m [16];
    logic [31:0] usr_m [8];
    logic [31:0] mem_m [256];
    logic [31:0] pc_m;
    int          rest_m;
    // expected state (written only by the stimulus)
    logic [31:0] sh_rf [16];
    logic [31:0] sh_usr [8];
    logic [31:0] sh_mem [256];
    logic [31:0] sh_pc;
    int          sh_rest;
    logic        sync_req;

    always #2 clk = ~clk;

    blkxfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .rf_rd_idx(rf_rd_idx), .rf_rd_usr(rf_rd_usr),
        .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
        .rf_wr_usr(rf_wr_usr), .rf_wr_data(rf_wr_data), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .status_restore(status_restore)
    );

    assign rf_rd_data = rf_rd_usr ? usr_m[rf_rd_idx[2:0]] : rf_m[rf_rd_idx];
    assign mem_rdata  = mem_m[mem_addr[9:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (sync_req) begin
            rf_m   <= sh_rf;
            usr_m  <= sh_usr;
            mem_m  <= sh_mem;
            pc_m   <= sh_pc;
            rest_m <= sh_rest;
        end else begin
            if (rf_we) begin
                if (rf_wr_usr) usr_m[rf_wr_idx[2:0]] <= rf_wr_data;
                else           rf_m[rf_wr_idx]       <= rf_wr_data;
            end
            if (mem_req && mem_ready && mem_we) mem_m[mem_addr[9:2]] <= mem_wdata;
            if (pc_we) pc_m <= pc_wdata;
            if (status_restore) rest_m <= rest_m + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit pre, input bit inc, input bit bank,
                                       input bit wb, input bit ld, input logic [3:0] rn,
                                       input logic [15:0] mask);
        return {4'hE, 3'b100, pre, inc, bank, wb, ld, rn, mask};
    endfunction

    task automatic compare_state(input string tag);
        int bad_rf = 0, bad_usr = 0, bad_mem = 0;
        for (int i = 0; i < 16; i++) if (rf_m[i] !== sh_rf[i]) bad_rf++;
        for (int i = 0; i < 7; i++) if (usr_m[i] !== sh_usr[i]) bad_usr++;
        for (int i = 0; i < 256; i++) if (mem_m[i] !== sh_mem[i]) bad_mem++;
        check(bad_rf == 0, tag, "current registers mismatching", bad_rf, 0);
        check(bad_usr == 0, tag, "user registers mismatching", bad_usr, 0);
        check(bad_mem == 0, tag, "memory words mismatching", bad_mem, 0);
        check(pc_m === sh_pc, tag, "pc", pc_m, sh_pc);
        check(rest_m == sh_rest, tag, "status restore count", rest_m, sh_rest);
    endtask

    task automatic run_xfer(input logic [31:0] ins, input string tag, input bit poke);
        logic [31:0] ea[$];
        logic [31:0] ed[$];
        bit          ew[$];
        bit          pre  = ins[24];
        bit          inc  = ins[23];
        bit          bank = ins[22];
        bit          wb   = ins[21];
        bit          ld   = ins[20];
        logic [3:0]  rn   = ins[19:16];
        logic [15:0] mask = ins[15:0];
        logic [31:0] pcv  = $urandom;
        logic [31:0] a;
        logic [31:0] acc;
        logic [31:0] v;
        bit          ovr  = bank && !mask[15];
        int nb = 0, waited = 0, start_c = 0, last_c = -1, done_c = -100;
        bit stalled = 0, first = 1, poked = 0;
        logic [31:0] st_addr = 0;

        // expected behaviour (R2, R3, R4, R5, R6, R7)
        a = sh_rf[rn];
        for (int s = 0; s < 16; s++) begin
            int r = inc ? s : 15 - s;
            if (mask[r]) begin
                bit u = ovr && r >= 8 && r <= 14;
                acc = pre ? (inc ? a + 4 : a - 4) : a;
                ea.push_back(acc);
                ew.push_back(!ld);
                if (ld) begin
                    v = sh_mem[acc[9:2]];
                    if (r == 15) begin
                        sh_pc = v;
                        if (bank) sh_rest++;
                    end else if (u) sh_usr[r-8] = v;
                    else sh_rf[r] = v;
                    ed.push_back(32'h0);
                end else begin
                    if (r == 15) v = pre ? pcv : pcv + 4;
                    else if (u) v = sh_usr[r-8];
                    else v = sh_rf[r];
                    sh_mem[acc[9:2]] = v;
                    ed.push_back(v);
                end
                a = inc ? a + 4 : a - 4;
            end
        end
        if (wb && mask != 0) sh_rf[rn] = a;

        @(negedge clk);
        pc_in = pcv; instr = ins; start = 1'b1; mem_ready = 1'b0;
        #1 start_c = cyc;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (poke && nb == 1 && !poked) begin
                start = 1'b1; instr = ins ^ 32'h0023_5A5A; poked = 1;  // R11
            end
            mem_ready = ($urandom % 4) != 0;
            #1;
            if (first) check(busy === 1'b1, "R9", "busy after start", busy, 1);
            first = 0;
            if (stalled) check(mem_req && mem_addr === st_addr, "R8", "held address", mem_addr, st_addr);
            stalled = 0;
            if (mem_req) begin
                if (mem_ready) begin
                    if (nb < ea.size()) begin
                        check(mem_addr === ea[nb], "R2/R3", "beat address", mem_addr, ea[nb]);
                        check(mem_we === ew[nb], "R1", "beat direction", mem_we, ew[nb]);
                        if (ew[nb]) check(mem_wdata === ed[nb], tag, "store data", mem_wdata, ed[nb]);
                    end
                    nb++;
                    last_c = cyc;
                end else begin
                    stalled = 1;
                    st_addr = mem_addr;
                end
            end
            if (done) begin
                done_c = cyc;
                break;
            end
            waited++;
            if (waited > 3000) begin
                check(0, tag, "transfer never finished", 0, 1);
                break;
            end
        end
        start = 1'b0; mem_ready = 1'b0;
        @(negedge clk); #1;
        check(nb == ea.size(), "R2", "beat count", nb, ea.size());
        if (ea.size() == 0)
            check(done_c == start_c + 1, "R10", "empty mask done cycle", done_c, start_c + 1);
        else
            check(done_c == last_c + 1, "R9", "done after last beat", done_c, last_c + 1);
        check(busy === 1'b0 && done === 1'b0, "R9", "idle after done", {busy, done}, 0);
        compare_state(tag);
    endtask

    initial begin
        #600000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; instr = '0; pc_in = '0; mem_ready = 1'b0; sync_req = 1'b0;
        for (int i = 0; i < 16; i++) sh_rf[i] = {$urandom} & 32'h0000_03FC;
        for (int i = 0; i < 8; i++) sh_usr[i] = $urandom;
        for (int i = 0; i < 256; i++) sh_mem[i] = $urandom;
        sh_pc = 32'h0; sh_rest = 0;
        repeat (2) @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk); #1;
        check(!busy && !done && !mem_req && !rf_we && !pc_we && !status_restore,
              "R12", "outputs in reset", {busy, done, mem_req, rf_we, pc_we, status_restore}, 0);
        @(negedge clk);
        sync_req = 1'b0;
        rst_n = 1'b1;

        // R1: wrong instruction class is ignored
        @(negedge clk);
        instr = 32'hEA00_00FF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1 check(!busy && !done && !mem_req, "R1", "wrong class ignored", {busy, done, mem_req}, 0);
            @(negedge clk);
        end
        compare_state("R1");

        run_xfer(mk(0, 1, 0, 0, 1, 4'd1, 16'h000F), "R2", 0);
        run_xfer(mk(1, 0, 0, 1, 0, 4'd2, 16'h00F0), "R4", 0);
        run_xfer(mk(1, 1, 0, 1, 1, 4'd3, 16'h8421), "R6", 0);
        run_xfer(mk(0, 0, 0, 0, 0, 4'd4, 16'h1234), "R3", 0);
        run_xfer(mk(0, 1, 1, 0, 1, 4'd5, 16'h7F00), "R5", 0);
        run_xfer(mk(1, 0, 1, 0, 0, 4'd6, 16'h4381), "R5", 0);
        run_xfer(mk(0, 0, 1, 1, 1, 4'd7, 16'hC100), "R6", 0);
        run_xfer(mk(1, 1, 1, 0, 0, 4'd0, 16'hFF00), "R6", 0);
        run_xfer(mk(0, 1, 0, 0, 0, 4'd8, 16'h8001), "R7", 0);
        run_xfer(mk(1, 0, 0, 0, 0, 4'd9, 16'h8002), "R7", 0);
        run_xfer(mk(1, 1, 0, 1, 1, 4'd10, 16'h0000), "R10", 0);
        run_xfer(mk(0, 1, 0, 1, 1, 4'd2, 16'h0006), "R4", 0);
        run_xfer(mk(0, 1, 0, 0, 1, 4'd11, 16'h00FF), "R11", 1);

        for (int n = 0; n < 120; n++) begin
            logic [15:0] m = (n % 3 == 0) ? 16'($urandom) : 16'($urandom & $urandom);
            logic [31:0] ins = mk($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                                  $urandom % 2, 4'($urandom), m);
            run_xfer(ins, "R3", ($countones(m) >= 2) && ($urandom % 8 == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule